// File: doc/BRIEF.md
# Programmable Power-On Reset Generator

This block produces a supervisory reset request for the logic that sits behind a supply monitor. It takes the digital flag of an external comparator that reports "supply below the first trip level" and a manual reset pin. It asserts its active-high reset request while either of them is active. Once both have gone quiet, it keeps the request asserted for a hold-off time and only then lets go.

The hold-off length is picked at run time by a 2-bit select that comes from nonvolatile control-register bits. Each of the four codes maps to a cycle count set by a parameter. Both asynchronous inputs are resynchronised with two-flop chains before the block uses them. The synchronous reset puts the block into the asserted state, so the request is high from the very first cycle after power-up. The output is a plain logic level; the open-drain pad and its pull-up sit outside the block.

Top module: `por_reset_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `reset_req_o` is 1. After `rst` falls, the supply flag is treated as low-supply until its synchronizer has refilled, so the full hold-off runs after reset.
- R2: A high `supply_low_i` drives `reset_req_o` to 1 and keeps it there for as long as the flag stays high.
- R3: A high `manual_rst_i` forces `reset_req_o` to 1 whatever the supply flag says.
- R4: With both inputs low, `reset_req_o` falls on the N-th rising edge at which both synchronized inputs are low. N is DLY_0, DLY_1, DLY_2 or DLY_3 for `dly_sel_i` = 0, 1, 2 or 3. Seen from the pins, the output falls 2+N edges after the last input falls.
- R5: If the supply flag goes high again before the hold-off ends, the count is discarded. A fresh count of N starts from zero once the flag has fallen again.
- R6: When `manual_rst_i` is released while the supply is good, the complete hold-off of N cycles runs before `reset_req_o` falls.
- R7: Each input passes through a two-flop synchronizer. A level applied between two edges first shows on `reset_req_o` after the 3rd rising edge. A high pulse that lasts one cycle is still captured, asserts reset and restarts the hold-off.
- R8: Once `reset_req_o` is 0, it stays 0 while both inputs stay low. Changes on `dly_sel_i` then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset; forces the asserted state |
| supply_low_i | input | 1 | Comparator flag, high when the supply is under the trip level (asynchronous) |
| manual_rst_i | input | 1 | Manual reset pin, active high (asynchronous) |
| dly_sel_i | input | 2 | Hold-off select from the control register |
| reset_req_o | output | 1 | Active-high reset request |

## Verification
The bench targets the exact release edge for every one of the four delay codes. A counter off by one, or a swapped code, moves the falling edge by a cycle or more. It drops the supply flag midway through a hold-off: a design that resumes the old count instead of restarting releases reset early. It releases the manual pin on a good supply and sends a single-cycle supply glitch: a missing or extra synchronizer stage shifts the 3-edge latency, and a design that forgets the glitch skips the fresh hold-off. It also toggles the delay select after release, where a design that re-evaluates the count would pulse reset for no reason.

// File: rtl/por_pkg.sv
package por_pkg;

    // Phase of the hold-off engine: holding the request, or released.
    typedef enum logic [0:0] {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } por_phase_e;

    // Synchronized copy of the two reset sources.
    typedef struct packed {
        logic supply_low;
        logic manual;
    } por_req_t;

    function automatic logic req_active(input por_req_t r);
        return r.supply_low | r.manual;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/por_delay_sel.sv
module por_delay_sel #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DLY_0 = 4,
    parameter int unsigned DLY_1 = 9,
    parameter int unsigned DLY_2 = 17,
    parameter int unsigned DLY_3 = 40
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] limit
);
    localparam logic [CNT_W-1:0] LIM_0 = CNT_W'(DLY_0);
    localparam logic [CNT_W-1:0] LIM_1 = CNT_W'(DLY_1);
    localparam logic [CNT_W-1:0] LIM_2 = CNT_W'(DLY_2);
    localparam logic [CNT_W-1:0] LIM_3 = CNT_W'(DLY_3);

    always_comb begin
        unique case (sel)
            2'd0:    limit = LIM_0;
            2'd1:    limit = LIM_1;
            2'd2:    limit = LIM_2;
            default: limit = LIM_3;
        endcase
    end
endmodule

// File: rtl/por_holdoff.sv
module por_holdoff
    import por_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             reset_req
);
    por_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (hold) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (phase == PH_HOLD) begin
            if (cnt_next >= {1'b0, limit}) begin
                phase <= PH_RUN;
            end else begin
                cnt <= cnt_next[CNT_W-1:0];
            end
        end
    end

    assign reset_req = (phase == PH_HOLD);
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen
    import por_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DLY_0       = 4,
    parameter int unsigned DLY_1       = 9,
    parameter int unsigned DLY_2       = 17,
    parameter int unsigned DLY_3       = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low_i,
    input  logic       manual_rst_i,
    input  logic [1:0] dly_sel_i,
    output logic       reset_req_o
);
    localparam int unsigned DLY_MAX = max4(DLY_0, DLY_1, DLY_2, DLY_3);
    localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);

    por_req_t         req_s;
    logic             hold_s;
    logic [CNT_W-1:0] limit;

    // Supply flag resets to "low supply" so the output starts asserted.
    por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sup (
        .clk(clk), .rst(rst), .d(supply_low_i), .q(req_s.supply_low)
    );

    por_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mr (
        .clk(clk), .rst(rst), .d(manual_rst_i), .q(req_s.manual)
    );

    assign hold_s = req_active(req_s);

    por_delay_sel #(
        .CNT_W(CNT_W), .DLY_0(DLY_0), .DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)
    ) u_sel (
        .sel(dly_sel_i), .limit(limit)
    );

    por_holdoff #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .hold(hold_s), .limit(limit), .reset_req(reset_req_o)
    );
endmodule

// File: rtl/por_reset_gen_chk.sv
module por_reset_gen_chk #(
    parameter int unsigned DLY_0 = 4,
    parameter int unsigned DLY_1 = 9,
    parameter int unsigned DLY_2 = 17,
    parameter int unsigned DLY_3 = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       sup_s,
    input logic       mr_s,
    input logic [1:0] dly_sel_i,
    input logic       reset_req_o
);
    localparam int GOOD_SAT = 1 << 20;

    function automatic int pick(input logic [1:0] s);
        case (s)
            2'd0:    return int'(DLY_0);
            2'd1:    return int'(DLY_1);
            2'd2:    return int'(DLY_2);
            default: return int'(DLY_3);
        endcase
    endfunction

    // Consecutive edges on which neither synchronized source was active.
    int good_q;
    always_ff @(posedge clk) begin
        if (rst || sup_s || mr_s) good_q <= 0;
        else if (good_q < GOOD_SAT) good_q <= good_q + 1;
    end

    AST_RESET_ASSERTS: assert property (@(posedge clk) rst |=> reset_req_o); // R1
    AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (rst) sup_s |=> reset_req_o); // R2
    AST_MANUAL_FORCES: assert property (@(posedge clk) disable iff (rst) mr_s |=> reset_req_o); // R3
    AST_RELEASE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_req_o) |-> (good_q == pick($past(dly_sel_i)))); // R4
    AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!reset_req_o && !sup_s && !mr_s) |=> !reset_req_o); // R8
endmodule

bind por_reset_gen por_reset_gen_chk #(
    .DLY_0(DLY_0), .DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)
) u_chk (
    .clk(clk),
    .rst(rst),
    .sup_s(req_s.supply_low),
    .mr_s(req_s.manual),
    .dly_sel_i(dly_sel_i),
    .reset_req_o(reset_req_o)
);

// File: tb/sim_por_reset_gen.sv
module sim_por_reset_gen;
    localparam int D0 = 4;
    localparam int D1 = 9;
    localparam int D2 = 17;
    localparam int D3 = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_low_i = 1'b0;
    logic       manual_rst_i = 1'b0;
    logic [1:0] dly_sel_i = 2'd0;
    logic       reset_req_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_tag = "R1";

    por_reset_gen #(.DLY_0(D0), .DLY_1(D1), .DLY_2(D2), .DLY_3(D3)) u0 (
        .clk(clk), .rst(rst), .supply_low_i(supply_low_i),
        .manual_rst_i(manual_rst_i), .dly_sel_i(dly_sel_i), .reset_req_o(reset_req_o)
    );

    always #5 clk = ~clk;

    function automatic int dly(input logic [1:0] s);
        case (s)
            2'd0:    return D0;
            2'd1:    return D1;
            2'd2:    return D2;
            default: return D3;
        endcase
    endfunction

    // Behavioural reference: pipeline of sampled inputs plus a run-length counter.
    bit m_sup[$];
    bit m_mr[$];
    int m_good = 0;
    bit m_rel = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_sup = '{1, 1};
            m_mr  = '{0, 0};
            m_good = 0;
            m_rel = 0;
            started = 1;
        end else begin
            if (m_sup[0] || m_mr[0]) begin
                m_good = 0;
                m_rel = 0;
            end else if (!m_rel) begin
                m_good++;
                if (m_good >= dly(dly_sel_i)) m_rel = 1;
            end
            void'(m_sup.pop_front());
            void'(m_mr.pop_front());
            m_sup.push_back(supply_low_i);
            m_mr.push_back(manual_rst_i);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done)
            check(reset_req_o === !m_rel, cur_tag, int'(reset_req_o), int'(!m_rel));
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until the output reaches lvl; compare with the expected count.
    task automatic wait_level(input logic lvl, input int exp, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (reset_req_o !== lvl && n < 300);
        check(n == exp, tag, n, exp);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: asserted during and after reset, full hold-off follows.
        cur_tag = "R1";
        @(negedge clk);
        cyc(3);
        check(reset_req_o === 1'b1, "R1 in reset", int'(reset_req_o), 1);
        rst = 1'b0;
        wait_level(1'b0, 2 + D0, "R1 first release");

        // R4: every delay code, measured from the last input fall.
        for (int s = 0; s < 4; s++) begin
            cur_tag = "R2";
            dly_sel_i = s[1:0];
            supply_low_i = 1'b1;
            cyc(6);
            check(reset_req_o === 1'b1, "R2 supply low", int'(reset_req_o), 1);
            cur_tag = "R4";
            supply_low_i = 1'b0;
            wait_level(1'b0, 2 + dly(s[1:0]), "R4 release count");
        end

        // R5: dip during hold-off restarts from zero.
        cur_tag = "R5";
        dly_sel_i = 2'd2;
        supply_low_i = 1'b1;
        cyc(4);
        supply_low_i = 1'b0;
        cyc(2 + D2 / 2);
        supply_low_i = 1'b1;
        cyc(3);
        supply_low_i = 1'b0;
        wait_level(1'b0, 2 + D2, "R5 restart");

        // R3 and R6: manual reset on a good supply, then full hold-off.
        cur_tag = "R3";
        dly_sel_i = 2'd1;
        manual_rst_i = 1'b1;
        cyc(8);
        check(reset_req_o === 1'b1, "R3 manual forces", int'(reset_req_o), 1);
        supply_low_i = 1'b1;
        cyc(3);
        supply_low_i = 1'b0;
        cyc(5);
        check(reset_req_o === 1'b1, "R3 manual overrides good supply", int'(reset_req_o), 1);
        cur_tag = "R6";
        manual_rst_i = 1'b0;
        wait_level(1'b0, 2 + D1, "R6 manual release");

        // R7: single-cycle glitch latency and fresh hold-off.
        cur_tag = "R7";
        dly_sel_i = 2'd0;
        supply_low_i = 1'b1;
        @(negedge clk);
        supply_low_i = 1'b0;
        check(reset_req_o === 1'b0, "R7 not yet", int'(reset_req_o), 0);
        @(negedge clk);
        check(reset_req_o === 1'b0, "R7 two edges", int'(reset_req_o), 0);
        @(negedge clk);
        check(reset_req_o === 1'b1, "R7 third edge", int'(reset_req_o), 1);
        wait_level(1'b0, D0, "R7 glitch hold-off");

        // R8: select changes after release are ignored.
        cur_tag = "R8";
        for (int k = 0; k < 12; k++) begin
            dly_sel_i = k[1:0];
            cyc(2);
            check(reset_req_o === 1'b0, "R8 stays released", int'(reset_req_o), 0);
        end

        // R1 again: mid-run reset re-asserts.
        cur_tag = "R1";
        rst = 1'b1;
        cyc(2);
        check(reset_req_o === 1'b1, "R1 re-reset", int'(reset_req_o), 1);
        rst = 1'b0;
        dly_sel_i = 2'd3;
        wait_level(1'b0, 2 + D3, "R1 release after re-reset");

        cyc(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule